// File: doc/BRIEF.md
# Compensated Nanosecond Time Counter

This block keeps a 64-bit time value in nanoseconds for packet timestamping. On every enabled clock it adds a small default step. When compensation is due, it adds a separate compensation step instead. This lets software trim the clock's effective frequency in steps finer than one reference period.

Compensation comes from two sources, and either one selects the alternate step for a tick. The first is a one-shot burst counter that spends one unit per tick. The second is a periodic down-counter that fires once every N enabled ticks. An optional wrap mode returns the counter to zero when it reaches a compare value, so the counter measures a repeating cycle time instead of absolute time.

Software uses a plain 32-bit register bus: a write strobe, a read strobe and a byte address. Read data is combinational.

Top module: `ns_time_counter`

## Requirements
- R1: After reset, every register reads zero: configuration, status, burst count, slow period, both count words, compare configuration and both compare words.
- R2: While the enable bit is clear, the count holds its value unless software writes it, and the burst count does not decrement.
- R3: The configuration register at 0x00 holds three fields. Bit 0 is enable, bits 7:4 are the default step (0 to 15 ns) and bits 19:8 are the compensation step (0 to 4095). Each enabled tick with no compensation due adds the default step.
- R4: The burst register at 0x08 is 24 bits wide. While it is nonzero, each enabled tick adds the compensation step and lowers the burst register by one. Reading the register returns the remaining count.
- R5: The slow period register at 0x0C holds a value N. When N is nonzero, every Nth enabled tick after N was written adds the compensation step. When N is zero, periodic compensation is off.
- R6: The count is read at 0x10 (low word) and 0x14 (high word). Reading the low word captures the high word at that instant, and a later read of 0x14 returns the captured value.
- R7: A write to 0x10 or 0x14 replaces that half of the count on the next clock. That clock's step is discarded.
- R8: Status bit 0 at 0x04 sets when the 64-bit addition carries out while wrap mode is off. It stays set until software writes 1 to it. Writing 0 leaves it unchanged.
- R9: The compare configuration register at 0x18 has a shadow enable at bit 17 and a reset enable at bit 0. The compare value sits at 0x1C (low word) and 0x20 (high word). With both enables set, an enabled tick that finds the count at or above the compare value loads zero, with no residue.
- R10: Unused register bits read as zero. Configuration, burst, slow period and compare registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one tick per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a low-word read captures the high word) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |

## Verification
- **Register writes:** a write takes effect at the clock edge that samples it.
- **Enable and count:** the count first moves on the edge after the enable write, and it still moves on the edge that registers the disable write. A run framed by enable, T-1 idle cycles and disable therefore spans exactly T ticks.
- **Sampling:** read data is combinational, so the bench samples it shortly after the falling edge, before the edge that performs the high-word capture.
- **Expected values:** burst, periodic and wrap results are worked out by tick index from the requirements.

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 24,
  parameter int SLOW_W  = 32,
  parameter int DEF_W   = 4,
  parameter int COMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int DEF_LSB = 4;
  localparam int COMP_LSB = 8;
  localparam int SHADOW_BIT = 17;
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_BURST = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_SLOW  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_CLO   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CHI   = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_CCFG  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_MLO   = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_MHI   = ADDR_W'('h20);

  logic              en, shadow, rst_en, ovf;
  logic [DEF_W-1:0]  def_inc;
  logic [COMP_W-1:0] comp_inc;
  logic [BURST_W-1:0] burst;
  logic [SLOW_W-1:0] slow_per, slow_cnt;
  logic [CNT_W-1:0]  count, cmp0, inc;
  logic [CNT_W:0]    sum;
  logic [DATA_W-1:0] hi_latch;

  wire w_cfg   = wr_en && addr == A_CFG;
  wire w_stat  = wr_en && addr == A_STAT;
  wire w_burst = wr_en && addr == A_BURST;
  wire w_slow  = wr_en && addr == A_SLOW;
  wire w_clo   = wr_en && addr == A_CLO;
  wire w_chi   = wr_en && addr == A_CHI;
  wire w_ccfg  = wr_en && addr == A_CCFG;
  wire w_mlo   = wr_en && addr == A_MLO;
  wire w_mhi   = wr_en && addr == A_MHI;
  wire cnt_wr  = w_clo || w_chi;
  wire lo_rd   = rd_en && addr == A_CLO;

  wire slow_fire = en && slow_per != '0 && slow_cnt == '0;
  wire use_comp  = burst != '0 || slow_fire;
  wire wrap_on   = shadow && rst_en;
  wire wrap_hit  = wrap_on && count >= cmp0;

  assign inc = use_comp ? CNT_W'(comp_inc) : CNT_W'(def_inc);
  assign sum = {1'b0, count} + {1'b0, inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      def_inc <= '0;
      comp_inc <= '0;
      shadow <= 1'b0;
      rst_en <= 1'b0;
      cmp0 <= '0;
    end else begin
      if (w_cfg) begin
        en <= wdata[0];
        def_inc <= wdata[DEF_LSB +: DEF_W];
        comp_inc <= wdata[COMP_LSB +: COMP_W];
      end
      if (w_ccfg) begin
        shadow <= wdata[SHADOW_BIT];
        rst_en <= wdata[0];
      end
      if (w_mlo) cmp0[DATA_W-1:0] <= wdata;
      if (w_mhi) cmp0[CNT_W-1:DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (w_clo) count[DATA_W-1:0] <= wdata;
    else if (w_chi) count[CNT_W-1:DATA_W] <= wdata;
    else if (en) count <= wrap_hit ? '0 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else if (en && !cnt_wr && !wrap_on && sum[CNT_W]) ovf <= 1'b1;
    else if (w_stat && wdata[0]) ovf <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst <= '0;
    else if (w_burst) burst <= wdata[BURST_W-1:0];
    else if (en && burst != '0) burst <= burst - BURST_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_per <= '0;
      slow_cnt <= '0;
    end else if (w_slow) begin
      slow_per <= wdata[SLOW_W-1:0];
      slow_cnt <= (wdata[SLOW_W-1:0] == '0) ? '0 : wdata[SLOW_W-1:0] - SLOW_W'(1);
    end else if (en && slow_per != '0) begin
      slow_cnt <= (slow_cnt == '0) ? slow_per - SLOW_W'(1) : slow_cnt - SLOW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_latch <= '0;
    else if (lo_rd) hi_latch <= count[CNT_W-1:DATA_W];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG: begin
        rdata[0] = en;
        rdata[DEF_LSB +: DEF_W] = def_inc;
        rdata[COMP_LSB +: COMP_W] = comp_inc;
      end
      A_STAT:  rdata[0] = ovf;
      A_BURST: rdata[BURST_W-1:0] = burst;
      A_SLOW:  rdata[SLOW_W-1:0] = slow_per;
      A_CLO:   rdata = count[DATA_W-1:0];
      A_CHI:   rdata = hi_latch;
      A_CCFG: begin
        rdata[SHADOW_BIT] = shadow;
        rdata[0] = rst_en;
      end
      A_MLO:   rdata = cmp0[DATA_W-1:0];
      A_MHI:   rdata = cmp0[CNT_W-1:DATA_W];
      default: rdata = '0;
    endcase
  end

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(count));
  a_r4_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && burst != '0 && !w_burst) |=> burst == $past(burst) - BURST_W'(1));
  a_r5_slow_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_per != '0) |-> slow_cnt < slow_per);
  a_r6_hi_capture: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> hi_latch == $past(count[CNT_W-1:DATA_W]));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(w_stat && wdata[0])) |=> ovf);
  a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && shadow && rst_en && count >= cmp0 && !cnt_wr) |=> count == '0);
endmodule

// File: tb/ns_time_counter_tb.sv
`timescale 1ns/1ps
module ns_time_counter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  ns_time_counter dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                         .addr(addr), .wdata(wdata), .rdata(rdata));

  always #2 clk = ~clk;

  localparam int NV = 7;
  localparam int V_DEF  [NV] = '{4, 4, 4, 2, 15, 4, 4};
  localparam int V_COMP [NV] = '{5, 5, 3, 7, 4095, 6, 5};
  localparam int V_BUR  [NV] = '{0, 3, 0, 2, 1, 0, 20};
  localparam int V_SLOW [NV] = '{0, 0, 4, 3, 0, 1, 0};
  localparam int V_TICK [NV] = '{10, 10, 10, 9, 5, 6, 8};
  localparam int V_EXP  [NV] = '{40, 43, 38, 43, 4155, 36, 40};
  localparam int V_REM  [NV] = '{0, 0, 0, 0, 0, 0, 12};

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] cfgw(input int d, input int c, input bit e);
    return (32'(c) << 8) | (32'(d) << 4) | 32'(e);
  endfunction

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(8'h00, v); chk("R1 cfg", v, 0);
    rd(8'h04, v); chk("R1 status", v, 0);
    rd(8'h08, v); chk("R1 burst", v, 0);
    rd(8'h10, v); chk("R1 count lo", v, 0);
    rd(8'h14, v); chk("R1 count hi", v, 0);
    rd(8'h18, v); chk("R1 cmp cfg", v, 0);
    // R10 readback with unused bits
    wr(8'h00, 32'hFFFF_FFFE); rd(8'h00, v); chk("R10 cfg", v, 32'h000F_FFF0);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk("R10 burst", v, 32'h00FF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk("R10 cmp cfg", v, 32'h0002_0001);
    wr(8'h1C, 32'h1234_5678); rd(8'h1C, v); chk("R10 cmp lo", v, 32'h1234_5678);
    wr(8'h0C, 32'h0000_0009); rd(8'h0C, v); chk("R10 slow", v, 32'h9);
    wr(8'h18, 0); wr(8'h1C, 0); wr(8'h00, 0);
    // R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      wr(8'h10, 0); wr(8'h14, 0);
      wr(8'h08, V_BUR[i]); wr(8'h0C, V_SLOW[i]);
      wr(8'h00, cfgw(V_DEF[i], V_COMP[i], 1'b1));
      idle(V_TICK[i] - 1);
      wr(8'h00, cfgw(V_DEF[i], V_COMP[i], 1'b0));
      rd(8'h10, v); chk($sformatf("R3/R4/R5 vector %0d count", i), v, V_EXP[i]);
      rd(8'h08, v); chk($sformatf("R4 vector %0d burst left", i), v, V_REM[i]);
    end
    // R2 hold while disabled (burst 12 left, count 40)
    idle(5);
    rd(8'h10, v); chk("R2 count held", v, 40);
    rd(8'h08, v); chk("R2 burst held", v, 12);
    // R7 write override while running
    wr(8'h08, 0); wr(8'h0C, 0);
    wr(8'h00, cfgw(4, 4, 1'b1));
    wr(8'h10, 32'h100); wr(8'h14, 32'h5);
    rd(8'h10, v); chk("R7 lo after writes", v, 32'h100);
    rd(8'h14, v); chk("R7 hi written", v, 32'h5);
    wr(8'h00, cfgw(4, 4, 1'b0));
    // R6 coherent split read across carry
    wr(8'h10, 32'hFFFF_FFF0); wr(8'h14, 0);
    wr(8'h00, cfgw(4, 4, 1'b1));
    rd(8'h10, v); chk("R6 lo at capture", v, 32'hFFFF_FFF0);
    idle(5);
    rd(8'h14, v); chk("R6 hi is captured value", v, 0);
    wr(8'h00, cfgw(4, 4, 1'b0));
    rd(8'h10, v); chk("R6 lo after carry", v, 32'h10);
    rd(8'h14, v); chk("R6 hi after carry", v, 1);
    // R8 overflow
    wr(8'h18, 0);
    wr(8'h10, 32'hFFFF_FFF8); wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h00, cfgw(4, 4, 1'b1));
    idle(1);
    wr(8'h00, cfgw(4, 4, 1'b0));
    rd(8'h04, v); chk("R8 ovf set", v, 1);
    rd(8'h10, v); chk("R8 count wrapped lo", v, 0);
    rd(8'h14, v); chk("R8 count wrapped hi", v, 0);
    wr(8'h04, 0); rd(8'h04, v); chk("R8 write 0 keeps", v, 1);
    wr(8'h04, 1); rd(8'h04, v); chk("R8 write 1 clears", v, 0);
    // R9 wrap mode
    wr(8'h10, 0); wr(8'h14, 0);
    wr(8'h1C, 20); wr(8'h20, 0);
    wr(8'h18, 32'h0002_0001);
    wr(8'h00, cfgw(4, 4, 1'b1));
    idle(7);
    wr(8'h00, cfgw(4, 4, 1'b0));
    rd(8'h10, v); chk("R9 wrapped count", v, 8);
    rd(8'h04, v); chk("R9 no ovf flag", v, 0);
    wr(8'h10, 0);
    wr(8'h18, 32'h0002_0000);
    wr(8'h00, cfgw(4, 4, 1'b1));
    idle(7);
    wr(8'h00, cfgw(4, 4, 1'b0));
    rd(8'h10, v); chk("R9 shadow alone no wrap", v, 32);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule